// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is the register and control logic for one parallel general-purpose I/O port of a small microcontroller. Each pin carries three pieces of state: a direction bit, an output bit that doubles as the pull-up request on inputs, and a sampled input level. A simple register bus reaches each of the three with its own write strobe and its own read strobe, sharing one write-data and one read-data bus.

On the pad side the block drives a per-pin output enable, output value and pull-up enable. It takes the raw pin levels, a pull-up disable shared by every port, and a sleep control that blocks the input path. Raw levels pass through a latch-then-flop synchronizer before they can be read. An asynchronous active-low reset clears the direction and output bits at once, so every pin floats even if no clock is running.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, oe_o and pu_o are all zero and reads of direction and output return 0; this takes effect as soon as rst_ni falls, without waiting for a clock edge.
- R2: A write with wr_dir_i loads wdata_i into the direction bits on the rising edge; oe_o equals the direction bits (1 = output) and a read with rd_dir_i returns them.
- R3: A write with wr_out_i loads wdata_i into the output bits; out_o equals the output bits and a read with rd_out_i returns them. Without wr_out_i or wr_pin_i the output bits keep their value.
- R4: pu_o bit n is 1 only when direction bit n is 0, output bit n is 1 and pud_i is 0; a pin set as output never has its pull-up on.
- R5: While pud_i is 1, every bit of pu_o is 0, whatever the direction and output bits hold.
- R6: A read with rd_pin_i returns synchronized pin levels: a pin_i change made while clk_i is high is not visible before the next rising edge and is visible after it.
- R7: While sleep_i is 1, the synchronizer input is forced to 0, so a pin read returns 0 after the next rising edge for any pin_i value.
- R8: A write with wr_pin_i toggles each output bit whose wdata_i bit is 1 and leaves bits whose wdata_i bit is 0 unchanged.
- R9: When wr_out_i and wr_pin_i are both high in one cycle, the plain output write wins and no toggle is applied.
- R10: rdata_o is 0 when no read strobe is high; with several read strobes high, direction has priority over output, and output over pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_dir_i | input | 1 | Write strobe, direction register |
| wr_out_i | input | 1 | Write strobe, output register |
| wr_pin_i | input | 1 | Write strobe, pin address (toggle) |
| wdata_i | input | 8 | Write data |
| rd_dir_i | input | 1 | Read strobe, direction register |
| rd_out_i | input | 1 | Read strobe, output register |
| rd_pin_i | input | 1 | Read strobe, synchronized pin levels |
| rdata_o | output | 8 | Read data |
| pin_i | input | 8 | Raw pin levels |
| pud_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep control, blocks input path |
| oe_o | output | 8 | Per-pin output enable |
| out_o | output | 8 | Per-pin output value |
| pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The assertions watch every cycle for the register updates after direction writes, output writes and toggles, for hold of the output bits when nothing writes them, for the pull-up never being on for an output pin or under the global disable, and for an idle read bus. Only the bench scenarios can show the asynchronous effect of reset between clock edges, the exact edge at which a pin change becomes readable, the sleep forcing of the input path, and the priority between simultaneous writes and reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DIR  = 2'd1,
    RD_OUT  = 2'd2,
    RD_PIN  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dir_i,
  input  logic             wr_out_i,
  input  logic             wr_pin_i,
  input  logic [Width-1:0] wdata_i,
  output logic [Width-1:0] dir_o,
  output logic [Width-1:0] out_o
);
  logic [Width-1:0] dir_q, out_q, out_d;

  // plain write beats toggle
  always_comb begin
    out_d = out_q;
    if (wr_out_i)      out_d = wdata_i;
    else if (wr_pin_i) out_d = out_q ^ wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir_i) dir_q <= wdata_i;
      out_q <= out_d;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [Width-1:0] pin_i,
  output logic [Width-1:0] sync_o
);
  for (genvar g = 0; g < Width; g++) begin : g_bit
    logic lat_q;
    logic ff_q;
    logic gated;

    // floating pins are masked in sleep
    assign gated = pin_i[g] & ~sleep_i;

    always_latch begin
      if (!clk_i) lat_q = gated;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= 1'b0;
      else         ff_q <= lat_q;
    end

    assign sync_o[g] = ff_q;
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned Width = 8
) (
  input  logic [Width-1:0] dir_i,
  input  logic [Width-1:0] out_i,
  input  logic             pud_i,
  output logic [Width-1:0] oe_o,
  output logic [Width-1:0] out_o,
  output logic [Width-1:0] pu_o
);
  for (genvar g = 0; g < Width; g++) begin : g_pad
    assign oe_o[g]  = dir_i[g];
    assign out_o[g] = out_i[g];
    assign pu_o[g]  = ~dir_i[g] & out_i[g] & ~pud_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dir_i,
  input  logic             wr_out_i,
  input  logic             wr_pin_i,
  input  logic [Width-1:0] wdata_i,
  input  logic             rd_dir_i,
  input  logic             rd_out_i,
  input  logic             rd_pin_i,
  output logic [Width-1:0] rdata_o,
  input  logic [Width-1:0] pin_i,
  input  logic             pud_i,
  input  logic             sleep_i,
  output logic [Width-1:0] oe_o,
  output logic [Width-1:0] out_o,
  output logic [Width-1:0] pu_o
);
  import gpio_pkg::*;

  logic [Width-1:0] dir_w, outreg_w, sync_w;
  rd_sel_e          rd_sel;

  gpio_regs #(.Width(Width)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_dir_i(wr_dir_i),
    .wr_out_i(wr_out_i),
    .wr_pin_i(wr_pin_i),
    .wdata_i (wdata_i),
    .dir_o   (dir_w),
    .out_o   (outreg_w)
  );

  gpio_sync #(.Width(Width)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_i),
    .pin_i  (pin_i),
    .sync_o (sync_w)
  );

  gpio_pad_ctrl #(.Width(Width)) u_pad (
    .dir_i(dir_w),
    .out_i(outreg_w),
    .pud_i(pud_i),
    .oe_o (oe_o),
    .out_o(out_o),
    .pu_o (pu_o)
  );

  always_comb begin
    if (rd_dir_i)      rd_sel = RD_DIR;
    else if (rd_out_i) rd_sel = RD_OUT;
    else if (rd_pin_i) rd_sel = RD_PIN;
    else               rd_sel = RD_NONE;
  end

  always_comb begin
    unique case (rd_sel)
      RD_DIR:  rdata_o = dir_w;
      RD_OUT:  rdata_o = outreg_w;
      RD_PIN:  rdata_o = sync_w;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned Width = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_dir_i,
  input logic             wr_out_i,
  input logic             wr_pin_i,
  input logic [Width-1:0] wdata_i,
  input logic             rd_dir_i,
  input logic             rd_out_i,
  input logic             rd_pin_i,
  input logic [Width-1:0] rdata_o,
  input logic             pud_i,
  input logic [Width-1:0] oe_o,
  input logic [Width-1:0] out_o,
  input logic [Width-1:0] pu_o
);
  p_dir_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> oe_o == $past(wdata_i));

  p_out_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out_i |=> out_o == $past(wdata_i));

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_out_i && !wr_pin_i) |=> $stable(out_o));

  p_pu_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & oe_o) == '0);

  p_pu_pud_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> pu_o == '0);

  p_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pin_i && !wr_out_i) |=> out_o == ($past(out_o) ^ $past(wdata_i)));

  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_dir_i && !rd_out_i && !rd_pin_i) |-> rdata_o == '0);

  p_rd_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_out_i && !rd_dir_i) |-> rdata_o == out_o);
endmodule

bind gpio_port gpio_port_chk #(.Width(Width)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_dir_i(wr_dir_i),
  .wr_out_i(wr_out_i),
  .wr_pin_i(wr_pin_i),
  .wdata_i (wdata_i),
  .rd_dir_i(rd_dir_i),
  .rd_out_i(rd_out_i),
  .rd_pin_i(rd_pin_i),
  .rdata_o (rdata_o),
  .pud_i   (pud_i),
  .oe_o    (oe_o),
  .out_o   (out_o),
  .pu_o    (pu_o)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/100ps
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_dir = 0, wr_out = 0, wr_pin = 0;
  logic [7:0] wdata = '0;
  logic       rd_dir = 0, rd_out = 0, rd_pin = 0;
  logic [7:0] rdata;
  logic [7:0] pin = '0;
  logic       pud = 0, sleep = 0;
  logic [7:0] oe, outv, pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_dir_i(wr_dir), .wr_out_i(wr_out), .wr_pin_i(wr_pin), .wdata_i(wdata),
    .rd_dir_i(rd_dir), .rd_out_i(rd_out), .rd_pin_i(rd_pin), .rdata_o(rdata),
    .pin_i(pin), .pud_i(pud), .sleep_i(sleep),
    .oe_o(oe), .out_o(outv), .pu_o(pu)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic d, logic o, logic p, logic [7:0] v);
    @(negedge clk);
    wr_dir = d; wr_out = o; wr_pin = p; wdata = v;
    @(negedge clk);
    wr_dir = 0; wr_out = 0; wr_pin = 0; wdata = '0;
  endtask

  task automatic rd(logic d, logic o, logic p, output logic [7:0] v);
    rd_dir = d; rd_out = o; rd_pin = p;
    #0.5 v = rdata;
    rd_dir = 0; rd_out = 0; rd_pin = 0;
    #0.1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    wr(1, 0, 0, 8'hF0);
    wr(0, 1, 0, 8'h3C);
    @(posedge clk); #1;
    rst_n = 0;
    #0.5;
    chk("R1 oe async", oe, 8'h00);
    chk("R1 pu async", pu, 8'h00);
    rd(1, 0, 0, v); chk("R1 dir read", v, 8'h00);
    rd(0, 1, 0, v); chk("R1 out read", v, 8'h00);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(1, 0, 0, 8'hA5);
    chk("R2 oe", oe, 8'hA5);
    rd(1, 0, 0, v); chk("R2 dir read", v, 8'hA5);
    wr(0, 1, 0, 8'h5A);
    chk("R3 out_o", outv, 8'h5A);
    rd(0, 1, 0, v); chk("R3 out read", v, 8'h5A);
    @(negedge clk); @(negedge clk);
    chk("R3 hold", outv, 8'h5A);
    rd(0, 0, 0, v); chk("R10 idle read", v, 8'h00);
    rd(1, 1, 1, v); chk("R10 dir priority", v, 8'hA5);
    rd(0, 1, 1, v); chk("R10 out priority", v, 8'h5A);
  endtask

  task automatic t_pullup;
    wr(1, 0, 0, 8'h0F);
    wr(0, 1, 0, 8'h33);
    chk("R4 pu", pu, 8'h30);
    pud = 1; #0.5;
    chk("R5 pud", pu, 8'h00);
    pud = 0; #0.5;
    chk("R4 pu restored", pu, 8'h30);
  endtask

  task automatic t_toggle;
    wr(0, 1, 0, 8'hC3);
    wr(0, 0, 1, 8'h0F);
    chk("R8 toggle", outv, 8'hCC);
    wr(0, 0, 1, 8'h00);
    chk("R8 zero no change", outv, 8'hCC);
    wr(0, 1, 1, 8'h11);
    chk("R9 write beats toggle", outv, 8'h11);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(posedge clk); #1;
    pin = 8'h96;
    rd(0, 0, 1, v); chk("R6 not yet", v, 8'h00);
    @(posedge clk); #1;
    rd(0, 0, 1, v); chk("R6 visible", v, 8'h96);
    pin = 8'h69;
    @(posedge clk); #1;
    rd(0, 0, 1, v); chk("R6 second pattern", v, 8'h69);
    sleep = 1;
    @(posedge clk); #1;
    rd(0, 0, 1, v); chk("R7 sleep gated", v, 8'h00);
    pin = 8'hFF;
    @(posedge clk); #1;
    rd(0, 0, 1, v); chk("R7 sleep gated ff", v, 8'h00);
    sleep = 0;
    @(posedge clk); #1;
    rd(0, 0, 1, v); chk("R7 wake", v, 8'hFF);
  endtask

  initial begin
    #1;
    chk("R1 oe in reset", oe, 8'h00);
    chk("R1 pu in reset", pu, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_regs();
    t_pullup();
    t_toggle();
    t_sync();
    t_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule